// File: doc/BRIEF.md
# Depth-Stencil Interleave Copy Engine

This block moves pixel data between a packed depth-stencil staging buffer and two separate surfaces, one holding depth and one holding stencil. A box of pixels is described by a width, a height and a number of slices. In the gather direction the engine reads each pixel's depth bytes and stencil byte from the two surfaces and writes them as one packed staging pixel. In the scatter direction it reads the packed staging pixel and writes its depth part and its stencil part to the two surfaces. A third format keeps only stencil, one byte per pixel, and leaves the depth surface untouched.

All traffic uses three independent byte-addressed memory ports: staging, depth and stencil. Each port has a valid/ready handshake and returns read data in the same cycle as the accepting ready. Data lanes are relative to the request address: lane 0 is the byte at the address. Staging addresses are built from a row stride and a layer stride. Each surface position is built from an origin, a row pitch and a per-slice row offset. A plain row-major translation stands in for the tiled layout. The engine walks slices, then rows, then pixels. It signals completion with a one-cycle done pulse.

Top module: `zs_interleave_dma`

## Requirements
- R1: After reset, busy and done are low and no port raises valid.
- R2: A start with width, height or slice count equal to zero raises done in the cycle after the start is sampled, and no port makes any request.
- R3: Pixels are processed slice by slice, row by row and pixel by pixel. The staging address of pixel p in row r of slice s is s*layer_stride + r*row_stride + p*B. B is 1 in stencil-only mode (mode 0 or 3), 4 in mode 1 and 8 in mode 2.
- R4: The depth address is (d_org_y + s*d_slice_rows + r)*d_pitch + d_org_x + 4*p. The stencil address is (s_org_y + s*s_slice_rows + r)*s_pitch + s_org_x + p.
- R5: Mode 1 (24-bit depth with stencil), gather: staging lanes 0..2 take depth bytes 0..2 and lane 3 takes the stencil byte, with staging byte enables 8'h0F.
- R6: Mode 2 (32-bit depth with stencil), gather: staging lanes 0..3 take depth bytes 0..3 and lane 4 takes the stencil byte, with byte enables 8'h1F. Lanes 5..7 are not written.
- R7: In stencil-only mode, staging lane 0 and the stencil byte are copied directly, with staging byte enables 8'h01. The depth port never raises valid.
- R8: Scatter (dir=1): depth receives staging lanes 0..3 with dep_be 4'h7 in mode 1 and 4'hF in mode 2. Stencil receives the staging byte at lane 3 in mode 1, lane 4 in mode 2 and lane 0 in stencil-only mode. Staging lanes 5..7 have no effect.
- R9: A request stalled by a low ready keeps its valid and address. The depth and stencil ports progress independently. A staging access and a surface access are never pending in the same cycle, so each pixel's source is complete before its destination is written.
- R10: done is high for exactly one cycle, in the cycle after the last destination handshake of the last pixel. busy is low while done is high. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy when idle |
| dir | input | 1 | 0 gather into staging, 1 scatter from staging |
| mode | input | 2 | 0/3 stencil only, 1 24-bit depth + stencil, 2 32-bit depth + stencil |
| width | input | DIM_W | Pixels per row |
| height | input | DIM_W | Rows per slice |
| slices | input | DIM_W | Number of slices |
| row_stride | input | ADDR_W | Staging bytes per row |
| layer_stride | input | ADDR_W | Staging bytes per slice |
| d_org_x | input | ADDR_W | Depth byte column of the first slice origin |
| d_org_y | input | ADDR_W | Depth row of the first slice origin |
| d_pitch | input | ADDR_W | Depth bytes per row |
| d_slice_rows | input | ADDR_W | Depth rows between slice origins |
| s_org_x | input | ADDR_W | Stencil byte column of the origin |
| s_org_y | input | ADDR_W | Stencil row of the first slice origin |
| s_pitch | input | ADDR_W | Stencil bytes per row |
| s_slice_rows | input | ADDR_W | Stencil rows between slice origins |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| stg_valid | output | 1 | Staging request valid |
| stg_ready | input | 1 | Staging request accepted |
| stg_we | output | 1 | Staging write (1) or read (0) |
| stg_addr | output | ADDR_W | Staging byte address |
| stg_be | output | 8 | Staging byte enables |
| stg_wdata | output | 64 | Staging write data |
| stg_rdata | input | 64 | Staging read data, valid with ready |
| dep_valid | output | 1 | Depth request valid |
| dep_ready | input | 1 | Depth request accepted |
| dep_we | output | 1 | Depth write (1) or read (0) |
| dep_addr | output | ADDR_W | Depth byte address |
| dep_be | output | 4 | Depth byte enables |
| dep_wdata | output | 32 | Depth write data |
| dep_rdata | input | 32 | Depth read data, valid with ready |
| stc_valid | output | 1 | Stencil request valid |
| stc_ready | input | 1 | Stencil request accepted |
| stc_we | output | 1 | Stencil write (1) or read (0) |
| stc_addr | output | ADDR_W | Stencil byte address |
| stc_wdata | output | 8 | Stencil write data |
| stc_rdata | input | 8 | Stencil read data, valid with ready |

## Verification
The bench builds the engine with its default DIM_W of 8 and ADDR_W of 20. Each memory is modelled as 4096 bytes. Depth and stencil pitches and slice offsets differ, so an error in the 4-byte versus 1-byte column step, or in the per-slice origin, gives a wrong address. Boxes with two slices and several rows cover the row and layer stride steps. Random ready patterns give independent stalls on the depth and stencil ports. Zero-width and zero-slice boxes, and a second start during a run, reach the completion corner cases.

// File: rtl/zs_interleave_dma.sv
module zs_interleave_dma #(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [1:0]        mode,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [DIM_W-1:0]  slices,
  input  logic [ADDR_W-1:0] row_stride,
  input  logic [ADDR_W-1:0] layer_stride,
  input  logic [ADDR_W-1:0] d_org_x,
  input  logic [ADDR_W-1:0] d_org_y,
  input  logic [ADDR_W-1:0] d_pitch,
  input  logic [ADDR_W-1:0] d_slice_rows,
  input  logic [ADDR_W-1:0] s_org_x,
  input  logic [ADDR_W-1:0] s_org_y,
  input  logic [ADDR_W-1:0] s_pitch,
  input  logic [ADDR_W-1:0] s_slice_rows,
  output logic              busy,
  output logic              done,
  output logic              stg_valid,
  input  logic              stg_ready,
  output logic              stg_we,
  output logic [ADDR_W-1:0] stg_addr,
  output logic [7:0]        stg_be,
  output logic [63:0]       stg_wdata,
  input  logic [63:0]       stg_rdata,
  output logic              dep_valid,
  input  logic              dep_ready,
  output logic              dep_we,
  output logic [ADDR_W-1:0] dep_addr,
  output logic [3:0]        dep_be,
  output logic [31:0]       dep_wdata,
  input  logic [31:0]       dep_rdata,
  output logic              stc_valid,
  input  logic              stc_ready,
  output logic              stc_we,
  output logic [ADDR_W-1:0] stc_addr,
  output logic [7:0]        stc_wdata,
  input  logic [7:0]        stc_rdata
);

  typedef enum logic [1:0] {IDLE, FETCH, STORE, FIN} state_t;

  state_t            state;
  logic              dir_q;
  logic [1:0]        mode_q;
  logic [DIM_W-1:0]  w_q, h_q, n_q, px, row, slc;
  logic [ADDR_W-1:0] stg_row, stg_slc, dy, sy, d_sy, s_sy;
  logic              d_ok, s_ok;
  logic [31:0]       dbuf;
  logic [7:0]        sbuf;

  logic has_depth, surf_phase, dep_hs, stc_hs, stg_hs, phase_done;
  logic last_px, last_row, last_slc;
  logic [ADDR_W-1:0] px_a, px_stg;
  logic [7:0] stg_lane;

  assign has_depth  = (mode_q == 2'd1) || (mode_q == 2'd2);
  assign surf_phase = (state == FETCH && !dir_q) || (state == STORE && dir_q);
  assign busy       = (state == FETCH) || (state == STORE);
  assign done       = (state == FIN);

  assign dep_valid = surf_phase && has_depth && !d_ok;
  assign stc_valid = surf_phase && !s_ok;
  assign stg_valid = busy && !surf_phase;
  assign dep_hs    = dep_valid && dep_ready;
  assign stc_hs    = stc_valid && stc_ready;
  assign stg_hs    = stg_valid && stg_ready;
  assign phase_done = surf_phase ?
      ((d_ok || !has_depth || dep_hs) && (s_ok || stc_hs)) : stg_hs;

  assign last_px  = (px  == w_q - DIM_W'(1));
  assign last_row = (row == h_q - DIM_W'(1));
  assign last_slc = (slc == n_q - DIM_W'(1));

  assign px_a   = ADDR_W'(px);
  assign px_stg = (mode_q == 2'd1) ? (px_a << 2) :
                  (mode_q == 2'd2) ? (px_a << 3) : px_a;

  assign stg_we   = !dir_q;
  assign dep_we   = dir_q;
  assign stc_we   = dir_q;
  assign stg_addr = stg_row + px_stg;
  assign dep_addr = dy * d_pitch + d_org_x + (px_a << 2);
  assign stc_addr = sy * s_pitch + s_org_x + px_a;

  assign stg_lane = (mode_q == 2'd1) ? stg_rdata[31:24] :
                    (mode_q == 2'd2) ? stg_rdata[39:32] : stg_rdata[7:0];

  always_comb begin
    case (mode_q)
      2'd1:    begin stg_wdata = {32'h0, sbuf, dbuf[23:0]}; stg_be = 8'h0F; end
      2'd2:    begin stg_wdata = {24'h0, sbuf, dbuf};       stg_be = 8'h1F; end
      default: begin stg_wdata = {56'h0, sbuf};             stg_be = 8'h01; end
    endcase
  end

  assign dep_be    = (mode_q == 2'd1) ? 4'h7 : 4'hF;
  assign dep_wdata = dbuf;
  assign stc_wdata = sbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      dir_q   <= 1'b0;
      mode_q  <= 2'd0;
      w_q     <= '0;
      h_q     <= '0;
      n_q     <= '0;
      px      <= '0;
      row     <= '0;
      slc     <= '0;
      stg_row <= '0;
      stg_slc <= '0;
      dy      <= '0;
      sy      <= '0;
      d_sy    <= '0;
      s_sy    <= '0;
      d_ok    <= 1'b0;
      s_ok    <= 1'b0;
      dbuf    <= '0;
      sbuf    <= '0;
    end else begin
      case (state)
        IDLE: if (start) begin
          dir_q   <= dir;
          mode_q  <= mode;
          w_q     <= width;
          h_q     <= height;
          n_q     <= slices;
          px      <= '0;
          row     <= '0;
          slc     <= '0;
          stg_row <= '0;
          stg_slc <= '0;
          dy      <= d_org_y;
          d_sy    <= d_org_y;
          sy      <= s_org_y;
          s_sy    <= s_org_y;
          d_ok    <= 1'b0;
          s_ok    <= 1'b0;
          state   <= (width == '0 || height == '0 || slices == '0) ? FIN : FETCH;
        end
        FETCH, STORE: begin
          if (dep_hs) begin
            d_ok <= 1'b1;
            if (!dir_q) dbuf <= dep_rdata;
          end
          if (stc_hs) begin
            s_ok <= 1'b1;
            if (!dir_q) sbuf <= stc_rdata;
          end
          if (stg_hs && dir_q) begin
            dbuf <= stg_rdata[31:0];
            sbuf <= stg_lane;
          end
          if (phase_done) begin
            d_ok <= 1'b0;
            s_ok <= 1'b0;
            if (state == FETCH) begin
              state <= STORE;
            end else if (!last_px) begin
              state <= FETCH;
              px    <= px + DIM_W'(1);
            end else if (!last_row) begin
              state   <= FETCH;
              px      <= '0;
              row     <= row + DIM_W'(1);
              stg_row <= stg_row + row_stride;
              dy      <= dy + ADDR_W'(1);
              sy      <= sy + ADDR_W'(1);
            end else if (!last_slc) begin
              state   <= FETCH;
              px      <= '0;
              row     <= '0;
              slc     <= slc + DIM_W'(1);
              stg_slc <= stg_slc + layer_stride;
              stg_row <= stg_slc + layer_stride;
              d_sy    <= d_sy + d_slice_rows;
              dy      <= d_sy + d_slice_rows;
              s_sy    <= s_sy + s_slice_rows;
              sy      <= s_sy + s_slice_rows;
            end else begin
              state <= FIN;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

module zs_interleave_dma_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        mode_q,
  input logic              stg_valid,
  input logic              stg_ready,
  input logic [ADDR_W-1:0] stg_addr,
  input logic              dep_valid,
  input logic              dep_ready,
  input logic [ADDR_W-1:0] dep_addr,
  input logic              stc_valid,
  input logic              stc_ready,
  input logic [ADDR_W-1:0] stc_addr
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stg_valid && !dep_valid && !stc_valid);

  assert_stg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stg_valid && !stg_ready |=> stg_valid && $stable(stg_addr));

  assert_dep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dep_valid && !dep_ready |=> dep_valid && $stable(dep_addr));

  assert_stc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stc_valid && !stc_ready |=> stc_valid && $stable(stc_addr));

  assert_phase_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stg_valid && (dep_valid || stc_valid)));

  assert_no_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (mode_q == 2'd0 || mode_q == 2'd3) |-> !dep_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind zs_interleave_dma zs_interleave_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_q(mode_q),
  .stg_valid(stg_valid), .stg_ready(stg_ready), .stg_addr(stg_addr),
  .dep_valid(dep_valid), .dep_ready(dep_ready), .dep_addr(dep_addr),
  .stc_valid(stc_valid), .stc_ready(stc_ready), .stc_addr(stc_addr)
);

// File: tb/zs_interleave_dma_tb.sv
module zs_interleave_dma_tb;
  localparam int CLK_P  = 10;
  localparam int DIM_W  = 8;
  localparam int ADDR_W = 20;
  localparam int RS = 32, LS = 128;
  localparam int DOX = 8, DOY = 2, DP = 64, DSR = 8;
  localparam int SOX = 3, SOY = 1, SP = 32, SSR = 6;

  typedef struct packed {
    logic             we;
    logic [ADDR_W-1:0] addr;
    logic [63:0]      data;
    logic [7:0]       be;
  } txn_t;

  logic clk = 0, rst_n = 0, start = 0, dir = 0;
  logic [1:0] mode = 0;
  logic [DIM_W-1:0] width = 0, height = 0, slices = 0;
  logic busy, done;
  logic stg_valid, stg_ready = 0, stg_we; logic [ADDR_W-1:0] stg_addr;
  logic [7:0] stg_be; logic [63:0] stg_wdata, stg_rdata;
  logic dep_valid, dep_ready = 0, dep_we; logic [ADDR_W-1:0] dep_addr;
  logic [3:0] dep_be; logic [31:0] dep_wdata, dep_rdata;
  logic stc_valid, stc_ready = 0, stc_we; logic [ADDR_W-1:0] stc_addr;
  logic [7:0] stc_wdata, stc_rdata;

  logic [7:0] stg_mem [4096];
  logic [7:0] dep_mem [4096];
  logic [7:0] stc_mem [4096];

  txn_t q_stg[$], q_dep[$], q_stc[$];
  int nchk = 0, nerr = 0;
  int cyc = 0, start_cyc = 0, done_cyc = 0, done_cnt = 0, last_hs = 0, hs_cnt = 0, dep_seen = 0;
  bit rnd = 0;
  string dreq = "R5";

  always #(CLK_P/2) clk = ~clk;

  zs_interleave_dma #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .mode(mode),
    .width(width), .height(height), .slices(slices),
    .row_stride(ADDR_W'(RS)), .layer_stride(ADDR_W'(LS)),
    .d_org_x(ADDR_W'(DOX)), .d_org_y(ADDR_W'(DOY)), .d_pitch(ADDR_W'(DP)), .d_slice_rows(ADDR_W'(DSR)),
    .s_org_x(ADDR_W'(SOX)), .s_org_y(ADDR_W'(SOY)), .s_pitch(ADDR_W'(SP)), .s_slice_rows(ADDR_W'(SSR)),
    .busy(busy), .done(done),
    .stg_valid(stg_valid), .stg_ready(stg_ready), .stg_we(stg_we), .stg_addr(stg_addr),
    .stg_be(stg_be), .stg_wdata(stg_wdata), .stg_rdata(stg_rdata),
    .dep_valid(dep_valid), .dep_ready(dep_ready), .dep_we(dep_we), .dep_addr(dep_addr),
    .dep_be(dep_be), .dep_wdata(dep_wdata), .dep_rdata(dep_rdata),
    .stc_valid(stc_valid), .stc_ready(stc_ready), .stc_we(stc_we), .stc_addr(stc_addr),
    .stc_wdata(stc_wdata), .stc_rdata(stc_rdata)
  );

  always_comb begin
    for (int i = 0; i < 8; i++) stg_rdata[i*8 +: 8] = stg_mem[12'(stg_addr + ADDR_W'(i))];
    for (int i = 0; i < 4; i++) dep_rdata[i*8 +: 8] = dep_mem[12'(dep_addr + ADDR_W'(i))];
    stc_rdata = stc_mem[12'(stc_addr)];
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] bmask(logic [7:0] be);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  task automatic port_hs(ref txn_t q[$], input string name, input string areq,
                         input logic we, input logic [ADDR_W-1:0] a,
                         input logic [63:0] wd, input logic [7:0] be);
    txn_t e;
    hs_cnt++;
    last_hs = cyc;
    if (q.size() == 0) begin
      chk(0, areq, {name, " unexpected request"}, 64'(a), 64'h0);
      return;
    end
    e = q.pop_front();
    chk(a == e.addr, areq, {name, " address"}, 64'(a), 64'(e.addr));
    chk(we == e.we, dreq, {name, " direction"}, 64'(we), 64'(e.we));
    if (e.we) begin
      chk(be == e.be, dreq, {name, " byte enables"}, 64'(be), 64'(e.be));
      chk((wd & bmask(e.be)) == (e.data & bmask(e.be)), dreq, {name, " data"},
          wd & bmask(e.be), e.data & bmask(e.be));
    end
  endtask

  // monitor: drives readies at the falling edge, samples just before the rising edge
  initial forever begin
    @(negedge clk);
    stg_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
    dep_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
    stc_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
    #(CLK_P/2 - 1);
    cyc++;
    if (rst_n) begin
      if (start && !busy && !done) start_cyc = cyc;
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (dep_valid) dep_seen++;
      if (stg_valid && (dep_valid || stc_valid))
        chk(0, "R9", "staging and surface pending together", 64'h1, 64'h0);
      if (stg_valid && stg_ready) begin
        port_hs(q_stg, "staging", "R3", stg_we, stg_addr, stg_wdata, stg_be);
        if (stg_we) for (int i = 0; i < 8; i++)
          if (stg_be[i]) stg_mem[12'(stg_addr + ADDR_W'(i))] = stg_wdata[i*8 +: 8];
      end
      if (dep_valid && dep_ready) begin
        port_hs(q_dep, "depth", "R4", dep_we, dep_addr, 64'(dep_wdata), {4'h0, dep_be});
        if (dep_we) for (int i = 0; i < 4; i++)
          if (dep_be[i]) dep_mem[12'(dep_addr + ADDR_W'(i))] = dep_wdata[i*8 +: 8];
      end
      if (stc_valid && stc_ready) begin
        port_hs(q_stc, "stencil", "R4", stc_we, stc_addr, 64'(stc_wdata), 8'h01);
        if (stc_we) stc_mem[12'(stc_addr)] = stc_wdata;
      end
    end
  end

  task automatic build(bit d_i, logic [1:0] m_i, int w, int h, int n);
    int spp, lane;
    spp  = (m_i == 2'd1) ? 4 : (m_i == 2'd2) ? 8 : 1;
    lane = (m_i == 2'd1) ? 3 : (m_i == 2'd2) ? 4 : 0;
    for (int s = 0; s < n; s++)
      for (int r = 0; r < h; r++)
        for (int p = 0; p < w; p++) begin
          int sa, da, ta;
          logic [63:0] pix;
          txn_t t;
          ta = s*LS + r*RS + p*spp;
          da = (DOY + s*DSR + r)*DP + DOX + 4*p;
          sa = (SOY + s*SSR + r)*SP + SOX + p;
          if (!d_i) begin
            if (m_i == 2'd1 || m_i == 2'd2) begin
              t = '{1'b0, ADDR_W'(da), 64'h0, 8'h0}; q_dep.push_back(t);
            end
            t = '{1'b0, ADDR_W'(sa), 64'h0, 8'h0}; q_stc.push_back(t);
            pix = '0;
            for (int i = 0; i < 4; i++) pix[i*8 +: 8] = dep_mem[12'(da + i)];
            if (m_i == 2'd1) begin pix[31:24] = stc_mem[12'(sa)]; t = '{1'b1, ADDR_W'(ta), pix, 8'h0F}; end
            else if (m_i == 2'd2) begin pix[39:32] = stc_mem[12'(sa)]; t = '{1'b1, ADDR_W'(ta), pix, 8'h1F}; end
            else t = '{1'b1, ADDR_W'(ta), {56'h0, stc_mem[12'(sa)]}, 8'h01};
            q_stg.push_back(t);
          end else begin
            t = '{1'b0, ADDR_W'(ta), 64'h0, 8'h0}; q_stg.push_back(t);
            pix = '0;
            for (int i = 0; i < 8; i++) pix[i*8 +: 8] = stg_mem[12'(ta + i)];
            if (m_i == 2'd1 || m_i == 2'd2) begin
              t = '{1'b1, ADDR_W'(da), {32'h0, pix[31:0]}, (m_i == 2'd1) ? 8'h07 : 8'h0F};
              q_dep.push_back(t);
            end
            t = '{1'b1, ADDR_W'(sa), {56'h0, pix[lane*8 +: 8]}, 8'h01}; q_stc.push_back(t);
          end
        end
  endtask

  task automatic run(bit d_i, logic [1:0] m_i, int w, int h, int n, bit rnd_i, bit restart, string req);
    int t;
    bit zero;
    zero = (w == 0) || (h == 0) || (n == 0);
    dreq = req;
    build(d_i, m_i, w, h, n);
    @(negedge clk);
    rnd = rnd_i; dir = d_i; mode = m_i;
    width = DIM_W'(w); height = DIM_W'(h); slices = DIM_W'(n);
    done_cnt = 0; hs_cnt = 0; dep_seen = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(0, "R10", "watchdog expired waiting for done", 64'(t), 64'h0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R10", "done pulse count", 64'(done_cnt), 64'h1);
    if (zero) begin
      chk(done_cyc == start_cyc + 1, "R2", "done cycle after start", 64'(done_cyc), 64'(start_cyc + 1));
      chk(hs_cnt == 0, "R2", "requests for empty box", 64'(hs_cnt), 64'h0);
    end else begin
      chk(done_cyc == last_hs + 1, "R10", "done cycle after last access", 64'(done_cyc), 64'(last_hs + 1));
    end
    chk(q_stg.size() == 0, "R3", "staging accesses missing", 64'(q_stg.size()), 64'h0);
    chk(q_dep.size() == 0, "R4", "depth accesses missing", 64'(q_dep.size()), 64'h0);
    chk(q_stc.size() == 0, "R4", "stencil accesses missing", 64'(q_stc.size()), 64'h0);
    if (m_i == 2'd0 || m_i == 2'd3)
      chk(dep_seen == 0, "R7", "depth valid cycles in stencil-only", 64'(dep_seen), 64'h0);
    q_stg.delete(); q_dep.delete(); q_stc.delete();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      stg_mem[i] = 8'($urandom); dep_mem[i] = 8'($urandom); stc_mem[i] = 8'($urandom);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {62'h0, busy, done}, 64'h0);
    chk(!stg_valid && !dep_valid && !stc_valid, "R1", "valids after reset",
        {61'h0, stg_valid, dep_valid, stc_valid}, 64'h0);

    run(1'b0, 2'd1, 3, 2, 2, 1'b0, 1'b0, "R5");
    run(1'b0, 2'd1, 3, 2, 2, 1'b1, 1'b0, "R5");
    run(1'b0, 2'd2, 2, 3, 2, 1'b1, 1'b0, "R6");
    run(1'b0, 2'd0, 4, 2, 1, 1'b1, 1'b0, "R7");
    run(1'b1, 2'd1, 3, 2, 2, 1'b1, 1'b0, "R8");
    run(1'b1, 2'd2, 2, 2, 2, 1'b1, 1'b0, "R8");
    run(1'b1, 2'd0, 5, 2, 2, 1'b1, 1'b0, "R8");
    run(1'b1, 2'd3, 2, 1, 1, 1'b0, 1'b0, "R7");
    run(1'b0, 2'd1, 0, 2, 2, 1'b1, 1'b0, "R2");
    run(1'b1, 2'd2, 2, 2, 0, 1'b0, 1'b0, "R2");
    run(1'b0, 2'd2, 3, 2, 1, 1'b1, 1'b1, "R10");

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule